// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block holds a 64-bit free-running tick counter and three compare channels, all reached through a small register bus. Software reads a fixed capability word, switches the counter on or off with a global control word, and sets up each channel with a mode word, a compare value and a 64-bit delivery route word. The route word is only stored and read back. When the counter equals a channel's compare value, the channel raises its interrupt output.

A channel fires once per equality in one-shot mode. In periodic mode it also re-arms itself: on each hit it adds the last period written by software to its compare value. A channel signals either as a level or as a pulse. In level mode a sticky status bit drives the output until software clears it by writing a 1. In edge mode the output is a single-cycle pulse and the status bit stays at 0.

The bus takes 32-bit or 64-bit accesses. Reads are combinational. Writes take effect at the next clock edge. An access that is not naturally aligned reads as zero and changes nothing.

Top module: `evt_timer`

## Requirements
- R1: Address 0x000 reads a fixed 64-bit capability word with these fields: bits 7:0 revision (0x01); bits 12:8 the index of the last channel (2); bit 13 = 1 for a 64-bit counter; bit 15 = 1 for legacy-route capable; bits 31:16 vendor code (0x1D0F); bits 63:32 tick period in femtoseconds (10,000,000). The full value is 0x0098_9680_1D0F_A201.
- R2: In the global control word at 0x010, bit 0 is the counter enable and bit 1 is the legacy-route flag. Both read back as written and both are 0 after reset. While bit 0 is 1, the counter at 0x0F0 increases by exactly one per clock. While bit 0 is 0, the counter holds its value.
- R3: A write to the counter takes effect only while the counter enable is 0. If the counter is enabled, the write is ignored and counting continues.
- R4: In one-shot mode (mode bit 3 = 0), a channel fires when the counter equals its compare value, and its compare value stays unchanged.
- R5: In periodic mode (mode bit 3 = 1), each hit adds the stored period to the compare value. A normal compare write sets both the compare value and the period.
- R6: If mode bit 6 is set, the next compare write loads only the period. The compare value is left as it was, and bit 6 clears to 0.
- R7: In level mode (mode bit 1 = 1) with interrupts enabled (mode bit 2 = 1), a hit sets the channel's status bit n at 0x020 one clock later, and irq_o[n] follows that bit. Writing 0 to the status bit leaves it set. Writing 1 to it clears it.
- R8: In edge mode (mode bit 1 = 0) with interrupts enabled, irq_o[n] is high for exactly the one clock after a hit, and status bit n stays 0.
- R9: If mode bit 2 is 0, a hit sets no status bit and raises no interrupt.
- R10: Channel n has its mode word at 0x100+0x20·n, its compare value at +0x08 and its route word at +0x10/+0x14. Only mode bits 1, 2, 3 and 6 can be written. Bits 63:32 of the mode word read as the constant permitted-line mask 0x00FF0000.
- R11: An access that is not naturally aligned (a 32-bit access off a 4-byte boundary, or a 64-bit access off an 8-byte boundary) reads as zero, and as a write it is ignored.
- R12: A 32-bit access at offset +4 reads or writes the upper half of the 64-bit register, with the data on bits 31:0. A 32-bit access at offset +0 reads or writes the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 64 | Write data; a 32-bit write uses bits 31:0 |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| rdata_o | output | 64 | Read data, valid in the same cycle as rd_i |
| irq_o | output | 3 | Interrupt output per channel |

## Verification
A channel whose compare value is wrong fires on the wrong tick. The first sign is irq_o rising one clock earlier or later than the bench predicts from the counter value at enable. A periodic reload with the wrong step shows up in the compare read-back right after the first hit. A status bit that clears on a write of 0, or never sets, is visible on the next read of 0x020 and on irq_o in the same cycle. A counter that steps by more than one per clock, or keeps counting while disabled, shows up as a difference between two counter reads a known number of clocks apart.

// File: rtl/evt_timer_pkg.sv
`timescale 1ns/1ps
package evt_timer_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 64;

  localparam logic [ADDR_W-1:0] OFS_CAP  = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_GCFG = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_STS  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 12'h0F0;

  // channel mode bits
  localparam int MB_LVL = 1;
  localparam int MB_IEN = 2;
  localparam int MB_PRD = 3;
  localparam int MB_LDP = 6;
  localparam logic [DATA_W-1:0] MODE_RW = 64'h4E;

  function automatic logic [DATA_W-1:0] merge64(input logic [DATA_W-1:0] old_v,
                                                input logic [DATA_W-1:0] new_v,
                                                input logic [DATA_W-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction
endpackage

// File: rtl/evt_counter.sv
`timescale 1ns/1ps
module evt_counter #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         we_i,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] wval_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (en_i)         cnt_q <= cnt_q + W'(1);
    else if (we_i)         cnt_q <= (cnt_q & ~wmask_i) | (wval_i & wmask_i);
  end

  assign cnt_o = cnt_q;

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_q == $past(cnt_q) + W'(1));
  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_channel.sv
`timescale 1ns/1ps
module evt_channel import evt_timer_pkg::*; #(
  parameter logic [31:0] IRQ_CAP = 32'h00FF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              run_i,
  input  logic              mode_we_i,
  input  logic              cmp_we_i,
  input  logic              rte_we_i,
  input  logic [DATA_W-1:0] wmask_i,
  input  logic [DATA_W-1:0] wval_i,
  input  logic              sts_clr_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic [DATA_W-1:0] rte_o,
  output logic              sts_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cmp_q, per_q, rte_q, mode_nx;
  logic lvl_q, ien_q, prd_q, ldp_q, sts_q, pls_q, hit;

  assign mode_o  = {IRQ_CAP, 25'b0, ldp_q, 2'b0, prd_q, ien_q, lvl_q, 1'b0};
  assign mode_nx = merge64(mode_o, wval_i, wmask_i & MODE_RW);
  assign hit     = run_i && (cnt_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0; per_q <= '0;
      lvl_q <= 1'b0; ien_q <= 1'b0; prd_q <= 1'b0; ldp_q <= 1'b0;
    end else if (mode_we_i) begin
      lvl_q <= mode_nx[MB_LVL];
      ien_q <= mode_nx[MB_IEN];
      prd_q <= mode_nx[MB_PRD];
      ldp_q <= mode_nx[MB_LDP];
      if (hit && prd_q) cmp_q <= cmp_q + per_q;
    end else if (cmp_we_i) begin
      per_q <= merge64(per_q, wval_i, wmask_i);
      if (ldp_q) ldp_q <= 1'b0;
      else       cmp_q <= merge64(cmp_q, wval_i, wmask_i);
    end else if (hit && prd_q) begin
      cmp_q <= cmp_q + per_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rte_q <= '0;
    else if (rte_we_i)   rte_q <= merge64(rte_q, wval_i, wmask_i);
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= 1'b0; pls_q <= 1'b0;
    end else begin
      if (hit && lvl_q && ien_q) sts_q <= 1'b1;
      else if (sts_clr_i)        sts_q <= 1'b0;
      pls_q <= hit && !lvl_q && ien_q;
    end
  end

  assign cmp_o = cmp_q;
  assign rte_o = rte_q;
  assign sts_o = sts_q;
  assign irq_o = lvl_q ? (sts_q && ien_q) : pls_q;

  p_oneshot_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !prd_q && !cmp_we_i) |=> $stable(cmp_q));
  p_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && prd_q && !cmp_we_i) |=> cmp_q == $past(cmp_q) + $past(per_q));
  p_ldp_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_i && ldp_q && !hit) |=> ($stable(cmp_q) && !ldp_q));
  p_sts_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q) |-> $past(lvl_q && ien_q && run_i));
  p_sts_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q && !sts_clr_i) |=> sts_q);
  p_edge_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ien_q && !mode_we_i) |=> !irq_o);
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer import evt_timer_pkg::*; #(
  parameter int          NUM_CH     = 3,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [31:0] TICK_FS    = 32'd10_000_000,
  parameter logic        LEGACY_CAP = 1'b1,
  parameter logic [31:0] IRQ_CAP    = 32'h00FF_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              wide_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int CH_IW = 3;
  localparam logic [4:0] LAST_CH = 5'(NUM_CH - 1);
  localparam logic [DATA_W-1:0] CAP_WORD =
    {TICK_FS, VENDOR_ID, LEGACY_CAP, 1'b0, 1'b1, LAST_CH, REV_ID};

  logic acc_ok, hi_half, wr_ok, sel_ch;
  logic [ADDR_W-1:0] qaddr;
  logic [CH_IW-1:0] ch_idx;
  logic [1:0] ch_sub;
  logic [DATA_W-1:0] wmask, wval, cnt, full;
  logic [1:0] gcfg_q;
  logic [NUM_CH-1:0] sts;
  logic [DATA_W-1:0] mode_rd [NUM_CH];
  logic [DATA_W-1:0] cmp_rd  [NUM_CH];
  logic [DATA_W-1:0] rte_rd  [NUM_CH];

  assign acc_ok  = wide_i ? (addr_i[2:0] == 3'b000) : (addr_i[1:0] == 2'b00);
  assign hi_half = addr_i[2];
  assign qaddr   = {addr_i[ADDR_W-1:3], 3'b000};
  assign wr_ok   = wr_i && acc_ok;
  assign sel_ch  = (qaddr[ADDR_W-1:8] == 4'h1);
  assign ch_idx  = qaddr[7:5];
  assign ch_sub  = qaddr[4:3];
  assign wmask   = wide_i ? '1 : (hi_half ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF});
  assign wval    = wide_i ? wdata_i : {2{wdata_i[31:0]}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             gcfg_q <= 2'b00;
    else if (wr_ok && qaddr == OFS_GCFG)     gcfg_q <= (gcfg_q & ~wmask[1:0]) | (wval[1:0] & wmask[1:0]);
  end

  evt_counter #(.W(DATA_W)) u_cnt (
    .clk_i, .rst_ni,
    .en_i    (gcfg_q[0]),
    .we_i    (wr_ok && qaddr == OFS_CNT),
    .wmask_i (wmask),
    .wval_i  (wval),
    .cnt_o   (cnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_me;
    assign hit_me = wr_ok && sel_ch && (ch_idx == CH_IW'(i));
    evt_channel #(.IRQ_CAP(IRQ_CAP)) u_ch (
      .clk_i, .rst_ni,
      .cnt_i     (cnt),
      .run_i     (gcfg_q[0]),
      .mode_we_i (hit_me && ch_sub == 2'd0),
      .cmp_we_i  (hit_me && ch_sub == 2'd1),
      .rte_we_i  (hit_me && ch_sub == 2'd2),
      .wmask_i   (wmask),
      .wval_i    (wval),
      .sts_clr_i (wr_ok && qaddr == OFS_STS && wval[i] && wmask[i]),
      .mode_o    (mode_rd[i]),
      .cmp_o     (cmp_rd[i]),
      .rte_o     (rte_rd[i]),
      .sts_o     (sts[i]),
      .irq_o     (irq_o[i])
    );
  end

  always_comb begin
    full = '0;
    unique case (qaddr)
      OFS_CAP:  full = CAP_WORD;
      OFS_GCFG: full = {62'b0, gcfg_q};
      OFS_STS:  full = {{(DATA_W-NUM_CH){1'b0}}, sts};
      OFS_CNT:  full = cnt;
      default:  full = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel_ch && ch_idx == CH_IW'(i)) begin
        case (ch_sub)
          2'd0:    full = mode_rd[i];
          2'd1:    full = cmp_rd[i];
          2'd2:    full = rte_rd[i];
          default: full = '0;
        endcase
      end
    end
  end

  assign rdata_o = (!rd_i || !acc_ok) ? '0 :
                   wide_i ? full :
                   hi_half ? {32'h0, full[63:32]} : {32'h0, full[31:0]};

  p_misalign_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !acc_ok) |=> $stable(gcfg_q));
endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic wr = 1'b0, rd = 1'b0, wide = 1'b0;
  logic [2:0] irq;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_timer u0 (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
                .wr_i(wr), .rd_i(rd), .wide_i(wide), .rdata_o(rdata), .irq_o(irq));

  typedef struct packed {
    logic        wr;
    logic        wwide;
    logic [11:0] waddr;
    logic [63:0] wdat;
    logic        rwide;
    logic [11:0] raddr;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b1, 12'h000, 64'h0, 1'b1, 12'h000, 64'h0098_9680_1D0F_A201},           // R1
    '{1'b0, 1'b0, 12'h000, 64'h0, 1'b0, 12'h004, 64'h0000_0000_0098_9680},           // R1 R12
    '{1'b0, 1'b0, 12'h000, 64'h0, 1'b1, 12'h004, 64'h0},                             // R11
    '{1'b1, 1'b0, 12'h130, 64'hCAFE_0001, 1'b0, 12'h130, 64'h0000_0000_CAFE_0001},   // R10
    '{1'b1, 1'b0, 12'h134, 64'h1234_5678, 1'b0, 12'h134, 64'h0000_0000_1234_5678},   // R10 R12
    '{1'b0, 1'b0, 12'h000, 64'h0, 1'b1, 12'h130, 64'h1234_5678_CAFE_0001},           // R12
    '{1'b1, 1'b0, 12'h132, 64'hFFFF_FFFF, 1'b1, 12'h130, 64'h1234_5678_CAFE_0001},   // R11
    '{1'b1, 1'b1, 12'h100, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 12'h100, 64'h00FF_0000_0000_004E}, // R10
    '{1'b1, 1'b1, 12'h100, 64'h0, 1'b1, 12'h100, 64'h00FF_0000_0000_0000},           // R10
    '{1'b1, 1'b1, 12'h0F0, 64'h1_0000_0005, 1'b1, 12'h0F0, 64'h1_0000_0005},         // R3
    '{1'b1, 1'b0, 12'h010, 64'h2, 1'b0, 12'h010, 64'h2},                             // R2
    '{1'b1, 1'b0, 12'h14C, 64'hA, 1'b1, 12'h148, 64'h0000_000A_0000_0000}            // R12
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic w, input logic [11:0] a, input logic [63:0] d);
    wide = w; addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic w, input logic [11:0] a, output logic [63:0] d);
    wide = w; addr = a; rd = 1'b1;
    #1;
    d = rdata;
    rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, v2;
    ticks(3);
    rst_n = 1'b1;
    ticks(1);

    // reset state
    bus_rd(1'b1, 12'h010, v); chk("R2 gcfg reset", v, 64'h0);
    bus_rd(1'b1, 12'h020, v); chk("R7 status reset", v, 64'h0);
    bus_rd(1'b1, 12'h0F0, v); chk("R2 counter reset", v, 64'h0);
    chk("R8 irq reset", {61'h0, irq}, 64'h0);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i].wr) bus_wr(VEC[i].wwide, VEC[i].waddr, VEC[i].wdat);
      bus_rd(VEC[i].rwide, VEC[i].raddr, v);
      chk($sformatf("table row %0d", i), v, VEC[i].exp);
    end
    bus_wr(1'b0, 12'h010, 64'h0);

    // R4 R7 one-shot, level mode on channel 0
    bus_wr(1'b1, 12'h0F0, 64'h0);
    bus_wr(1'b1, 12'h108, 64'd10);
    bus_wr(1'b0, 12'h100, 64'h6);
    bus_wr(1'b0, 12'h010, 64'h1);
    ticks(10);
    chk("R4 no irq before match", {63'h0, irq[0]}, 64'h0);
    ticks(1);
    chk("R7 irq after match", {63'h0, irq[0]}, 64'h1);
    bus_rd(1'b0, 12'h020, v); chk("R7 status set", v, 64'h1);
    bus_rd(1'b1, 12'h108, v); chk("R4 compare kept", v, 64'd10);
    bus_wr(1'b0, 12'h020, 64'h0);
    bus_rd(1'b0, 12'h020, v); chk("R7 write 0 keeps status", v, 64'h1);
    chk("R7 irq held", {63'h0, irq[0]}, 64'h1);
    bus_wr(1'b0, 12'h020, 64'h1);
    bus_rd(1'b0, 12'h020, v); chk("R7 write 1 clears status", v, 64'h0);
    chk("R7 irq cleared", {63'h0, irq[0]}, 64'h0);

    // R2 counting, R3 write while running
    bus_rd(1'b1, 12'h0F0, v);
    ticks(5);
    bus_rd(1'b1, 12'h0F0, v2); chk("R2 step one per clock", v2, v + 64'd5);
    bus_wr(1'b1, 12'h0F0, 64'hFFFF);
    bus_rd(1'b1, 12'h0F0, v); chk("R3 write ignored while enabled", v, v2 + 64'd1);
    bus_wr(1'b0, 12'h010, 64'h0);
    bus_rd(1'b1, 12'h0F0, v);
    ticks(3);
    bus_rd(1'b1, 12'h0F0, v2); chk("R2 hold when disabled", v2, v);

    // R5 R8 periodic, edge mode on channel 1
    bus_wr(1'b0, 12'h100, 64'h0);
    bus_wr(1'b1, 12'h0F0, 64'h0);
    bus_wr(1'b0, 12'h120, 64'hC);
    bus_wr(1'b1, 12'h128, 64'd10);
    bus_wr(1'b0, 12'h010, 64'h1);
    ticks(10);
    chk("R8 no pulse before match", {63'h0, irq[1]}, 64'h0);
    ticks(1);
    chk("R8 pulse after match", {63'h0, irq[1]}, 64'h1);
    bus_rd(1'b1, 12'h128, v); chk("R5 first reload", v, 64'd20);
    bus_rd(1'b0, 12'h020, v); chk("R8 status stays 0", v, 64'h0);
    ticks(1);
    chk("R8 pulse one cycle", {63'h0, irq[1]}, 64'h0);
    ticks(9);
    chk("R5 second hit pulse", {63'h0, irq[1]}, 64'h1);
    bus_rd(1'b1, 12'h128, v); chk("R5 second reload", v, 64'd30);
    ticks(10);
    chk("R5 third hit pulse", {63'h0, irq[1]}, 64'h1);
    bus_rd(1'b1, 12'h128, v); chk("R5 third reload", v, 64'd40);

    // R6 period-only load
    bus_wr(1'b0, 12'h010, 64'h0);
    bus_wr(1'b1, 12'h0F0, 64'h0);
    bus_wr(1'b1, 12'h128, 64'd10);
    bus_wr(1'b0, 12'h120, 64'h4C);
    bus_wr(1'b1, 12'h128, 64'd4);
    bus_rd(1'b1, 12'h128, v); chk("R6 compare unchanged", v, 64'd10);
    bus_rd(1'b0, 12'h120, v); chk("R6 load flag cleared", v, 64'hC);
    bus_wr(1'b0, 12'h010, 64'h1);
    ticks(11);
    bus_rd(1'b1, 12'h128, v); chk("R6 reload by new period", v, 64'd14);
    chk("R6 pulse", {63'h0, irq[1]}, 64'h1);

    // R9 interrupt disabled, level mode on channel 2
    bus_wr(1'b0, 12'h010, 64'h0);
    bus_wr(1'b0, 12'h120, 64'h0);
    bus_wr(1'b1, 12'h0F0, 64'h0);
    bus_wr(1'b1, 12'h148, 64'd5);
    bus_wr(1'b0, 12'h140, 64'h2);
    bus_wr(1'b0, 12'h010, 64'h1);
    ticks(10);
    chk("R9 no irq", {61'h0, irq}, 64'h0);
    bus_rd(1'b0, 12'h020, v); chk("R9 no status", v, 64'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule